// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Generator

This block turns a deliberate, sustained press of two push-buttons into a system reset. Both active-low button inputs must be seen pressed together, without a break, for a multi-second hold time before the two reset outputs activate. A short or one-handed press never resets the system. Software can watch the same buttons for a short-press interrupt, and the hard reset remains available for the case where software no longer responds.

A static select level picks one of two hold lengths. Each length is given in milliseconds and turned into a clock-cycle count from a clock-frequency parameter, so a simulation can use short delays. The reset lasts exactly as long as both buttons stay down after the hold completes. There is no minimum width and no pulse at power-up. The first output is an open-drain style pull-low enable and the second is a driven active-high level. An undervoltage flag, synchronous to the clock, overrides everything: it releases both outputs and discards any hold progress.

Top module: `dual_press_reset`

## Requirements
- R1: A reset is produced only when both `btn_a_n` and `btn_b_n` are low together for the full hold count L. The outputs activate on the (L+3)-th rising edge, counting as edge 1 the first edge at which both inputs are low. One button alone never activates them.
- R2: L is CLK_HZ*SHORT_MS/1000 cycles while `dly_sel` is 0, and CLK_HZ*LONG_MS/1000 cycles while `dly_sel` is 1.
- R3: `rst1_drive_low` (1 = pull the line low) and `rst2_out` (1 = reset active) always hold the same value and change on the same edge.
- R4: Once the outputs are active, a 1 sampled on either button input clears both outputs on the third rising edge from that sample, however briefly they were active.
- R5: While `rst_n` is low and after it rises, both outputs are 0. No reset pulse is produced at start-up.
- R6: While `uv_flag` is 1, the buttons are ignored. Both outputs are 0 from the first edge that samples `uv_flag` high, even if they were active.
- R7: Releasing either button before the hold completes discards the progress. A later press must last a full L cycles again.
- R8: While both buttons stay held after activation, the outputs stay active indefinitely and the hold count saturates without wrapping.
- R9: When `uv_flag` returns to 0 with both buttons still held, a full new hold of L cycles starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low block reset |
| btn_a_n | input | 1 | First push-button, active-low, asynchronous |
| btn_b_n | input | 1 | Second push-button, active-low, asynchronous |
| dly_sel | input | 1 | Static hold-length select: 0 short, 1 long |
| uv_flag | input | 1 | Undervoltage indication, synchronous, active-high |
| rst1_drive_low | output | 1 | Open-drain reset: 1 enables the pull-low driver |
| rst2_out | output | 1 | Driven active-high reset |

## Verification
Each button passes through two synchroniser stages and then through the output register. A press therefore appears at the outputs L+3 edges after it is first sampled, and a release clears the outputs three edges after it is sampled. `uv_flag` bypasses the synchroniser, so it clears the outputs on the edge that samples it. The bench reference model delays the buttons through queues of its own and predicts each output for the next edge. It compares on the falling edge, half a period after every update, so no comparison depends on the order of processes at a clock edge. The stimulus places the presses so that the edge just before expiry, the expiry edge, early releases and undervoltage recovery all fall inside compared cycles.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

  // Hold length in clock cycles for a period given in milliseconds.
  function automatic longint unsigned ms_to_cycles(input longint unsigned clk_hz,
                                                   input longint unsigned ms);
    return (clk_hz * ms) / 64'd1000;
  endfunction

  function automatic longint unsigned max_u64(input longint unsigned a,
                                              input longint unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold the values 0..max_val.
  function automatic int cnt_bits(input longint unsigned max_val);
    int n;
    n = 1;
    while ((n < 63) && ((64'd1 << n) <= max_val)) n++;
    return n;
  endfunction

endpackage

// File: rtl/lpr_sync2.sv
module lpr_sync2 #(
  parameter int         W    = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= INIT;
      stage2 <= INIT;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;

endmodule

// File: rtl/lpr_hold_timer.sv
module lpr_hold_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          done
);

  logic at_limit;

  assign at_limit = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (!at_limit) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = at_limit;

endmodule

// File: rtl/lpr_out_stage.sv
module lpr_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pull_low_en,
  output logic level_high
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_low_en <= 1'b0;
    else        pull_low_en <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_high <= 1'b0;
    else        level_high <= fire;
  end

endmodule

// File: rtl/dual_press_reset.sv
module dual_press_reset #(
  parameter longint unsigned CLK_HZ   = 1_000_000,
  parameter longint unsigned SHORT_MS = 7500,
  parameter longint unsigned LONG_MS  = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_a_n,
  input  logic btn_b_n,
  input  logic dly_sel,
  input  logic uv_flag,
  output logic rst1_drive_low,
  output logic rst2_out
);
  import lpr_pkg::*;

  localparam longint unsigned SHORT_CYC = ms_to_cycles(CLK_HZ, SHORT_MS);
  localparam longint unsigned LONG_CYC  = ms_to_cycles(CLK_HZ, LONG_MS);
  localparam longint unsigned MAX_CYC   = max_u64(SHORT_CYC, LONG_CYC);
  localparam int              CW        = cnt_bits(MAX_CYC);
  localparam logic [CW-1:0]   SHORT_L   = CW'(SHORT_CYC);
  localparam logic [CW-1:0]   LONG_L    = CW'(LONG_CYC);

  logic [1:0]    btn_sync_n;
  logic          both_held;
  logic          hold_run;
  logic [CW-1:0] hold_limit;
  logic [CW-1:0] hold_cnt;
  logic          hold_done;
  logic          fire;

  lpr_sync2 #(.W(2), .INIT(2'b11)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({btn_b_n, btn_a_n}),
    .q_sync  (btn_sync_n)
  );

  assign both_held  = ~btn_sync_n[0] & ~btn_sync_n[1];
  assign hold_run   = both_held & ~uv_flag;
  assign hold_limit = dly_sel ? LONG_L : SHORT_L;

  lpr_hold_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (hold_run),
    .limit (hold_limit),
    .cnt   (hold_cnt),
    .done  (hold_done)
  );

  assign fire = hold_run & hold_done;

  lpr_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .pull_low_en (rst1_drive_low),
    .level_high  (rst2_out)
  );

endmodule

// File: rtl/lpr_checker.sv
module lpr_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          uv_flag,
  input logic          rst1_drive_low,
  input logic          rst2_out,
  input logic          both_held,
  input logic          hold_run,
  input logic [CW-1:0] hold_cnt,
  input logic [CW-1:0] hold_limit,
  input logic          hold_done
);

  AST_OUT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    rst1_drive_low == rst2_out); // R3

  AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst2_out) |-> $past(hold_done)); // R1

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !both_held |=> !rst2_out); // R4

  AST_UV_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> (!rst2_out && !rst1_drive_low)); // R6

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !both_held |=> (hold_cnt == '0)); // R7

  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_run && hold_cnt == hold_limit) |=> (hold_cnt == hold_limit || hold_cnt == '0)); // R8

  AST_UV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> (hold_cnt == '0)); // R9

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!rst2_out && !rst1_drive_low); // R5
    end
  end

endmodule

bind dual_press_reset lpr_checker #(.CW(CW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .uv_flag        (uv_flag),
  .rst1_drive_low (rst1_drive_low),
  .rst2_out       (rst2_out),
  .both_held      (both_held),
  .hold_run       (hold_run),
  .hold_cnt       (hold_cnt),
  .hold_limit     (hold_limit),
  .hold_done      (hold_done)
);

// File: tb/dual_press_reset_tb.sv
module dual_press_reset_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TB_HZ      = 1000;
  localparam int TB_SHORT   = 20;
  localparam int TB_LONG    = 35;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_a_n = 1'b1;
  logic btn_b_n = 1'b1;
  logic dly_sel = 1'b0;
  logic uv_flag = 1'b0;
  logic rst1_drive_low;
  logic rst2_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_req = "R5";

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_press_reset #(
    .CLK_HZ   (TB_HZ),
    .SHORT_MS (TB_SHORT),
    .LONG_MS  (TB_LONG)
  ) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .btn_a_n        (btn_a_n),
    .btn_b_n        (btn_b_n),
    .dly_sel        (dly_sel),
    .uv_flag        (uv_flag),
    .rst1_drive_low (rst1_drive_low),
    .rst2_out       (rst2_out)
  );

  // Reference model: hold length in cycles computed from the requirement.
  function automatic int want_hold(input bit sel);
    return sel ? (TB_HZ * TB_LONG) / 1000 : (TB_HZ * TB_SHORT) / 1000;
  endfunction

  bit a_hist[$];
  bit b_hist[$];
  int pressed_for;
  bit expect_on;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      a_hist = '{1'b1, 1'b1};
      b_hist = '{1'b1, 1'b1};
      pressed_for = 0;
      expect_on = 1'b0;
    end else begin
      bit a_seen;
      bit b_seen;
      a_seen = a_hist.pop_front();
      b_seen = b_hist.pop_front();
      if (uv_flag || a_seen || b_seen) begin
        expect_on = 1'b0;
        pressed_for = 0;
      end else begin
        expect_on = (pressed_for >= want_hold(dly_sel));
        if (pressed_for < want_hold(dly_sel)) pressed_for++;
      end
      a_hist.push_back(btn_a_n);
      b_hist.push_back(btn_b_n);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rst2_out !== expect_on) begin
        errors++;
        $display("FAIL %s rst2_out actual=%b expected=%b cycle=%0d", cur_req, rst2_out, expect_on, cycles);
      end
      checks++;
      if (rst1_drive_low !== expect_on) begin
        errors++;
        $display("FAIL R3 rst1_drive_low actual=%b expected=%b cycle=%0d", rst1_drive_low, expect_on, cycles);
      end
    end
  end

  always @(posedge clk) begin
    if (!done && cycles > WATCHDOG) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // R5: quiet during and after reset
    cur_req = "R5";
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(30);

    // R1/R2 short hold, then R4 release
    cur_req = "R1";
    dly_sel = 1'b0;
    btn_a_n = 1'b0;
    btn_b_n = 1'b0;
    wait_cyc(40);
    cur_req = "R4";
    btn_a_n = 1'b1;
    wait_cyc(10);

    // R1: one button alone never resets
    cur_req = "R1";
    btn_b_n = 1'b0;
    wait_cyc(60);
    btn_b_n = 1'b1;
    wait_cyc(5);

    // R2: long hold selected
    cur_req = "R2";
    dly_sel = 1'b1;
    wait_cyc(3);
    btn_a_n = 1'b0;
    btn_b_n = 1'b0;
    wait_cyc(50);
    cur_req = "R4";
    btn_b_n = 1'b1;
    wait_cyc(10);

    // R4: activation followed by a one-cycle release
    cur_req = "R4";
    dly_sel = 1'b0;
    wait_cyc(3);
    btn_b_n = 1'b0;
    wait_cyc(24);
    btn_a_n = 1'b1;
    wait_cyc(1);
    btn_a_n = 1'b1;
    btn_b_n = 1'b1;
    wait_cyc(8);

    // R7: early release discards progress
    cur_req = "R7";
    btn_a_n = 1'b0;
    btn_b_n = 1'b0;
    wait_cyc(12);
    btn_a_n = 1'b1;
    wait_cyc(1);
    btn_a_n = 1'b0;
    wait_cyc(30);

    // R8: long hold, saturation without wrap
    cur_req = "R8";
    wait_cyc(150);

    // R6: undervoltage forces release while held
    cur_req = "R6";
    uv_flag = 1'b1;
    wait_cyc(10);

    // R9: recovery restarts the hold from zero
    cur_req = "R9";
    uv_flag = 1'b0;
    wait_cyc(30);
    btn_a_n = 1'b1;
    btn_b_n = 1'b1;
    wait_cyc(8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule